// File: doc/BRIEF.md
# Packed Add/Subtract/Average Unit

This unit takes two 64-bit operands, `fs` and `ft`, and treats them as vectors of equal lanes: eight bytes, four halfwords, two words or a single doubleword. In every lane it performs the same operation, which is addition, subtraction (`fs` minus `ft`) or a rounding average. The result is written to the 64-bit output `fd`. Each lane is handled on its own. No carry or borrow crosses a lane boundary.

The operation is chosen by a 5-bit format code and a 6-bit function code taken from an instruction word. The encoding selects the lane width and one of three overflow policies:

- wraparound, which keeps only the low bits of each lane;
- signed clamping;
- unsigned clamping.

Overflow, carry and faults are never reported. A pair of codes that the unit does not recognise yields a zero result and a one-cycle illegal-operation flag. Both outputs are registered, so a strobed operation appears on the outputs one clock later.

Top module: `simd_addsub_unit`

## Requirements
- R1: After reset, `fd` is zero and `illegal` is low.
- R2: An operation accepted on a rising edge with `op_valid` high appears on `fd` and `illegal` after that same edge. While `op_valid` is low, `fd` keeps its value and `illegal` is low.
- R3: Wraparound add and subtract keep only the low bits of each lane for all four lane widths.
- R4: Signed saturating add and subtract clamp to 0x7F/0x80 for byte lanes and to 0x7FFF/0x8000 for halfword lanes, on positive and negative overflow respectively.
- R5: Unsigned saturating add clamps a lane to all ones (0xFF or 0xFFFF) when the unsigned sum does not fit in the lane.
- R6: Unsigned saturating subtract clamps a lane to zero when `fs` is below `ft` in that lane.
- R7: Subtraction computes `fs` minus `ft` in every lane, never `ft` minus `fs`.
- R8: Average treats lanes as unsigned and returns (a + b + 1) >> 1, computed one bit wider than the lane, so that 0xFF and 0xFF give 0xFF.
- R9: Function code 0 adds and function code 1 subtracts, with these format codes:
  - 11000: signed-saturating halfword
  - 11001: unsigned-saturating halfword
  - 11010: wraparound halfword
  - 11011: wraparound word
  - 11100: signed-saturating byte
  - 11101: unsigned-saturating byte
  - 11110: wraparound byte
  - 11111: wraparound doubleword

  With function code 0 only, format 10011 gives the byte average and format 10010 gives the halfword average.
- R10: Any other format/function pair makes `fd` zero and raises `illegal` for exactly that one result cycle.
- R11: Lanes are independent: a carry or borrow in one lane never changes a neighbouring lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe for the current cycle |
| fmt_code | input | 5 | Format field selecting lane width and policy |
| func_code | input | 6 | Function field selecting add or subtract |
| fs | input | 64 | First operand (minuend) |
| ft | input | 64 | Second operand (subtrahend) |
| fd | output | 64 | Registered packed result |
| illegal | output | 1 | Registered flag for an unrecognised code pair |

## Verification
The assertions assume that `op_valid` and the code and operand inputs are settled before each rising edge. They also assume that `op_valid` stays low throughout reset, because the illegal flag is checked against the strobe seen one cycle earlier. The bench meets both conditions by changing inputs only on falling edges and by holding the strobe low until reset has been released. Operands either come from fixed corner patterns or are drawn from a bench-local xorshift generator. Both sources drive any 64-bit value, so they place no extra limits on the data.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

    typedef enum logic [1:0] {
        OPK_ADD = 2'd0,
        OPK_SUB = 2'd1,
        OPK_AVG = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        POL_WRAP = 2'd0,
        POL_SCLAMP = 2'd1,
        POL_UCLAMP = 2'd2
    } clamp_pol_e;

    typedef enum logic [1:0] {
        LANE_8 = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_sel_e;

    typedef struct packed {
        logic       legal;
        op_kind_e   kind;
        clamp_pol_e pol;
        lane_sel_e  width;
    } op_ctl_t;

endpackage

// File: rtl/simd_op_decoder.sv
module simd_op_decoder
    import simd_addsub_pkg::*;
#(
    parameter int FMT_W  = 5,
    parameter int FUNC_W = 6
) (
    input  logic [FMT_W-1:0]  fmt_code,
    input  logic [FUNC_W-1:0] func_code,
    output op_ctl_t           ctl
);

    localparam logic [FUNC_W-1:0] FN_ADD = FUNC_W'(0);
    localparam logic [FUNC_W-1:0] FN_SUB = FUNC_W'(1);

    always_comb begin
        ctl = '{legal: 1'b0, kind: OPK_ADD, pol: POL_WRAP, width: LANE_8};
        if (func_code == FN_ADD || func_code == FN_SUB) begin
            ctl.kind  = (func_code == FN_SUB) ? OPK_SUB : OPK_ADD;
            ctl.legal = 1'b1;
            case (fmt_code)
                5'b11000: begin ctl.pol = POL_SCLAMP; ctl.width = LANE_16; end
                5'b11001: begin ctl.pol = POL_UCLAMP; ctl.width = LANE_16; end
                5'b11010: begin ctl.pol = POL_WRAP;   ctl.width = LANE_16; end
                5'b11011: begin ctl.pol = POL_WRAP;   ctl.width = LANE_32; end
                5'b11100: begin ctl.pol = POL_SCLAMP; ctl.width = LANE_8;  end
                5'b11101: begin ctl.pol = POL_UCLAMP; ctl.width = LANE_8;  end
                5'b11110: begin ctl.pol = POL_WRAP;   ctl.width = LANE_8;  end
                5'b11111: begin ctl.pol = POL_WRAP;   ctl.width = LANE_64; end
                5'b10011: begin
                    ctl.kind  = OPK_AVG;
                    ctl.width = LANE_8;
                    ctl.legal = (func_code == FN_ADD);
                end
                5'b10010: begin
                    ctl.kind  = OPK_AVG;
                    ctl.width = LANE_16;
                    ctl.legal = (func_code == FN_ADD);
                end
                default: ctl.legal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_addsub_pkg::*;
#(
    parameter int LW = 8
) (
    input  op_kind_e      kind,
    input  clamp_pol_e    pol,
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    output logic [LW-1:0] y
);

    localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};
    localparam logic [LW-1:0] UMAX = {LW{1'b1}};
    localparam logic [LW:0]   ONE  = {{LW{1'b0}}, 1'b1};

    logic [LW:0]   u_sum;
    logic [LW:0]   u_dif;
    logic [LW:0]   s_res;
    logic          s_ovf;
    logic [LW-1:0] wrap_v;

    always_comb begin
        u_sum  = {1'b0, a} + {1'b0, b};
        u_dif  = {1'b0, a} - {1'b0, b};
        s_res  = (kind == OPK_SUB) ? ({a[LW-1], a} - {b[LW-1], b})
                                   : ({a[LW-1], a} + {b[LW-1], b});
        s_ovf  = s_res[LW] ^ s_res[LW-1];
        wrap_v = (kind == OPK_SUB) ? u_dif[LW-1:0] : u_sum[LW-1:0];
        if (kind == OPK_AVG) begin
            y = LW'((u_sum + ONE) >> 1);
        end else begin
            case (pol)
                POL_SCLAMP: y = s_ovf ? (s_res[LW] ? SMIN : SMAX) : s_res[LW-1:0];
                POL_UCLAMP: begin
                    if (kind == OPK_SUB) y = u_dif[LW] ? '0 : wrap_v;
                    else                 y = u_sum[LW] ? UMAX : wrap_v;
                end
                default:    y = wrap_v;
            endcase
        end
    end

endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
    import simd_addsub_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int FMT_W  = 5,
    parameter int FUNC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [FMT_W-1:0]  fmt_code,
    input  logic [FUNC_W-1:0] func_code,
    input  logic [DATA_W-1:0] fs,
    input  logic [DATA_W-1:0] ft,
    output logic [DATA_W-1:0] fd,
    output logic              illegal
);

    localparam int N8  = DATA_W / 8;
    localparam int N16 = DATA_W / 16;
    localparam int N32 = DATA_W / 32;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              bad;
    } unit_state_t;

    op_ctl_t           ctl;
    logic [DATA_W-1:0] y8;
    logic [DATA_W-1:0] y16;
    logic [DATA_W-1:0] y32;
    logic [DATA_W-1:0] y64;
    unit_state_t       st_d;
    unit_state_t       st_q;

    simd_op_decoder #(.FMT_W(FMT_W), .FUNC_W(FUNC_W)) u_dec (
        .fmt_code (fmt_code),
        .func_code(func_code),
        .ctl      (ctl)
    );

    for (genvar g = 0; g < N8; g++) begin : g_l8
        simd_lane_alu #(.LW(8)) u_alu (
            .kind(ctl.kind), .pol(ctl.pol),
            .a(fs[g*8 +: 8]), .b(ft[g*8 +: 8]), .y(y8[g*8 +: 8])
        );
    end
    for (genvar g = 0; g < N16; g++) begin : g_l16
        simd_lane_alu #(.LW(16)) u_alu (
            .kind(ctl.kind), .pol(ctl.pol),
            .a(fs[g*16 +: 16]), .b(ft[g*16 +: 16]), .y(y16[g*16 +: 16])
        );
    end
    for (genvar g = 0; g < N32; g++) begin : g_l32
        simd_lane_alu #(.LW(32)) u_alu (
            .kind(ctl.kind), .pol(ctl.pol),
            .a(fs[g*32 +: 32]), .b(ft[g*32 +: 32]), .y(y32[g*32 +: 32])
        );
    end
    simd_lane_alu #(.LW(DATA_W)) u_alu64 (
        .kind(ctl.kind), .pol(ctl.pol), .a(fs), .b(ft), .y(y64)
    );

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (op_valid) begin
            if (!ctl.legal) begin
                st_d.res = '0;
                st_d.bad = 1'b1;
            end else begin
                case (ctl.width)
                    LANE_8:  st_d.res = y8;
                    LANE_16: st_d.res = y16;
                    LANE_32: st_d.res = y32;
                    default: st_d.res = y64;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fd      = st_q.res;
    assign illegal = st_q.bad;

endmodule

// File: rtl/simd_addsub_checker.sv
module simd_addsub_checker #(
    parameter int DATA_W = 64,
    parameter int FMT_W  = 5,
    parameter int FUNC_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [FMT_W-1:0]  fmt_code,
    input logic [FUNC_W-1:0] func_code,
    input logic [DATA_W-1:0] fs,
    input logic [DATA_W-1:0] ft,
    input logic [DATA_W-1:0] fd,
    input logic              illegal
);

    a_r10_flag_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(op_valid));

    a_r10_zero_when_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (fd == '0));

    a_r2_hold_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(fd) && !illegal));

    a_r3_dword_wrap_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && func_code == FUNC_W'(1) && fmt_code == 5'b11111)
        |=> (fd == $past(fs - ft)));

    a_r9_avg_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && func_code == FUNC_W'(0) && fmt_code == 5'b10011) |=> !illegal);

    a_r10_avg_sub_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && func_code == FUNC_W'(1) && fmt_code == 5'b10010) |=> illegal);

endmodule

bind simd_addsub_unit simd_addsub_checker #(
    .DATA_W(DATA_W), .FMT_W(FMT_W), .FUNC_W(FUNC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .fmt_code(fmt_code),
    .func_code(func_code), .fs(fs), .ft(ft), .fd(fd), .illegal(illegal)
);

// File: tb/tb_simd_addsub_unit.sv
module tb_simd_addsub_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  fmt_code = '0;
    logic [5:0]  func_code = '0;
    logic [63:0] fs = '0;
    logic [63:0] ft = '0;
    logic [63:0] fd;
    logic        illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_addsub_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .fmt_code(fmt_code),
        .func_code(func_code), .fs(fs), .ft(ft), .fd(fd), .illegal(illegal)
    );

    function automatic logic [63:0] next_rand();
        rng ^= rng << 13;
        rng ^= rng >> 7;
        rng ^= rng << 17;
        return rng;
    endfunction

    // Reference model: returns {illegal, result}
    function automatic logic [64:0] ref_op(input logic [4:0] fm, input logic [5:0] fn,
                                           input logic [63:0] a, input logic [63:0] b);
        int lw; int kind; int pol;
        logic [63:0] r;
        lw = 0; kind = (fn == 6'd1) ? 1 : 0; pol = 0;
        if (fn > 6'd1) return {1'b1, 64'h0};
        case (fm)
            5'b11000: begin lw = 16; pol = 1; end
            5'b11001: begin lw = 16; pol = 2; end
            5'b11010: lw = 16;
            5'b11011: lw = 32;
            5'b11100: begin lw = 8; pol = 1; end
            5'b11101: begin lw = 8; pol = 2; end
            5'b11110: lw = 8;
            5'b11111: lw = 64;
            5'b10011: begin lw = 8;  kind = 2; end
            5'b10010: begin lw = 16; kind = 2; end
            default: lw = 0;
        endcase
        if (lw == 0 || (kind == 2 && fn != 6'd0)) return {1'b1, 64'h0};
        if (lw == 64) return {1'b0, (kind == 1) ? a - b : a + b};
        r = '0;
        for (int i = 0; i < 64 / lw; i++) begin
            longint ua, ub, sa, sb, v, m;
            m  = (longint'(1) << lw) - 1;
            ua = longint'((a >> (i * lw))) & m;
            ub = longint'((b >> (i * lw))) & m;
            sa = (ua > (m >> 1)) ? ua - m - 1 : ua;
            sb = (ub > (m >> 1)) ? ub - m - 1 : ub;
            if (kind == 2)      v = (ua + ub + 1) >>> 1;
            else if (pol == 1) begin
                v = (kind == 1) ? sa - sb : sa + sb;
                if (v > (m >> 1)) v = m >> 1;
                if (v < -(m >> 1) - 1) v = -(m >> 1) - 1;
            end else if (pol == 2) begin
                v = (kind == 1) ? ua - ub : ua + ub;
                if (v > m) v = m;
                if (v < 0) v = 0;
            end else v = (kind == 1) ? ua - ub : ua + ub;
            r |= (64'(v & m)) << (i * lw);
        end
        return {1'b0, r};
    endfunction

    task automatic check(input string req, input logic [63:0] exp_fd, input logic exp_bad);
        n_chk++;
        if (fd !== exp_fd || illegal !== exp_bad) begin
            n_bad++;
            $display("FAIL %s: fd=%h illegal=%b expected fd=%h illegal=%b",
                     req, fd, illegal, exp_fd, exp_bad);
        end
    endtask

    // Drive one op on a falling edge, sample after the capturing edge
    task automatic run_op(input logic [4:0] fm, input logic [5:0] fn,
                          input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op_valid = 1'b1; fmt_code = fm; func_code = fn; fs = a; ft = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", 64'h0, 1'b0);
    endtask

    task automatic t_wrap();
        run_op(5'b11110, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
        check("R11 R3 byte add", 64'h0, 1'b0);
        run_op(5'b11010, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001);
        check("R11 R3 half add", 64'h0, 1'b0);
        run_op(5'b11011, 6'd1, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001);
        check("R11 R3 word sub", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run_op(5'b11111, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        check("R3 dword add", 64'h0, 1'b0);
    endtask

    task automatic t_signed_clamp();
        run_op(5'b11100, 6'd0, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101);
        check("R4 byte pos", 64'h7F7F_7F7F_7F7F_7F7F, 1'b0);
        run_op(5'b11100, 6'd1, 64'h8080_8080_8080_8080, 64'h0101_0101_0101_0101);
        check("R4 byte neg", 64'h8080_8080_8080_8080, 1'b0);
        run_op(5'b11000, 6'd0, 64'h7FFF_8000_7FFF_0005, 64'h0001_FFFF_0000_0003);
        check("R4 half mixed", 64'h7FFF_8000_7FFF_0008, 1'b0);
    endtask

    task automatic t_unsigned_clamp();
        run_op(5'b11101, 6'd0, 64'hF0F0_F0F0_0101_0101, 64'h2020_2020_0101_0101);
        check("R5 byte add", 64'hFFFF_FFFF_0202_0202, 1'b0);
        run_op(5'b11001, 6'd0, 64'hFFFF_0001_8000_1234, 64'h0001_0001_8000_0000);
        check("R5 half add", 64'hFFFF_0002_FFFF_1234, 1'b0);
        run_op(5'b11101, 6'd1, 64'h1020_1020_1020_1020, 64'h2010_2010_2010_2010);
        check("R6 byte sub", 64'h0010_0010_0010_0010, 1'b0);
        run_op(5'b11001, 6'd1, 64'h0000_0010_FFFF_0003, 64'h0001_0010_0001_0004);
        check("R6 half sub", 64'h0000_0000_FFFE_0000, 1'b0);
    endtask

    task automatic t_order();
        run_op(5'b11110, 6'd1, 64'h0505_0505_0505_0505, 64'h0303_0303_0303_0303);
        check("R7 fs-ft", 64'h0202_0202_0202_0202, 1'b0);
        run_op(5'b11110, 6'd1, 64'h0303_0303_0303_0303, 64'h0505_0505_0505_0505);
        check("R7 swapped", 64'hFEFE_FEFE_FEFE_FEFE, 1'b0);
    endtask

    task automatic t_average();
        run_op(5'b10011, 6'd0, 64'hFF01_00FE_FF01_00FE, 64'hFF02_0100_FF02_0100);
        check("R8 byte avg", 64'hFF02_017F_FF02_017F, 1'b0);
        run_op(5'b10010, 6'd0, 64'hFFFF_0000_0001_8000, 64'hFFFF_0001_0002_8001);
        check("R8 half avg", 64'hFFFF_0001_0002_8001, 1'b0);
    endtask

    task automatic t_illegal_and_hold();
        run_op(5'b11110, 6'd0, 64'h0102_0304_0506_0708, 64'h0101_0101_0101_0101);
        check("R2 latency", 64'h0203_0405_0607_0809, 1'b0);
        fs = 64'hDEAD_BEEF_DEAD_BEEF; ft = 64'h1; fmt_code = 5'b11111;
        repeat (3) @(negedge clk);
        check("R2 idle hold", 64'h0203_0405_0607_0809, 1'b0);
        run_op(5'b10011, 6'd1, 64'h1234, 64'h5678);
        check("R10 avg with sub", 64'h0, 1'b1);
        @(negedge clk);
        check("R10 flag one cycle", 64'h0, 1'b0);
        run_op(5'b00000, 6'd0, 64'h1234, 64'h5678);
        check("R10 bad format", 64'h0, 1'b1);
        run_op(5'b11110, 6'd2, 64'h1234, 64'h5678);
        check("R10 bad function", 64'h0, 1'b1);
    endtask

    task automatic t_sweep();
        logic [4:0] codes [10] = '{5'b11000, 5'b11001, 5'b11010, 5'b11011, 5'b11100,
                                   5'b11101, 5'b11110, 5'b11111, 5'b10011, 5'b10010};
        for (int c = 0; c < 10; c++) begin
            for (int fn = 0; fn < 2; fn++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [63:0] a, b;
                    logic [64:0] e;
                    a = next_rand(); b = next_rand();
                    if (k == 0) b = a ^ 64'h8080_8080_8080_8080;
                    e = ref_op(codes[c], 6'(fn), a, b);
                    run_op(codes[c], 6'(fn), a, b);
                    check("R9 sweep", e[63:0], e[64]);
                end
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wrap();
        t_signed_clamp();
        t_unsigned_clamp();
        t_order();
        t_average();
        t_illegal_and_hold();
        t_sweep();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

endmodule